// File: doc/BRIEF.md
# CAN Driver Enable and Bus Idle Integration

This block sits between the configuration of a CAN controller and its pin drivers. A two-bit driver-enable field selects which of the two transmit outputs is driven. The receive comparator is enabled whenever at least one driver is enabled. When the field is zero, both outputs are tri-stated and the comparator is switched off. The field is the only control input, and clearing it leaves all other controller state alone.

After the drivers are switched on from the fully disabled state, the node must not join bus traffic at once. The block counts consecutive recessive bit samples, using the sampled receive level qualified by a once-per-bit strobe from the bit-timing logic. When eleven of them have arrived in a row, it raises a bus-ready flag that releases the frame engine. A dominant sample during that count starts the count again. Once bus-ready is set, it stays set until the field returns to zero, so normal dominant traffic and changes between nonzero driver settings do not affect it.

Top module: `can_drv_integ`

## Requirements
- R1: With `drv_en` = 2'b00, `tx0_oe`, `tx1_oe` and `rx_cmp_en` are all 0 in the same cycle.
- R2: `drv_en` bit 0 enables `tx0_oe` and bit 1 enables `tx1_oe` (01: tx0 only, 10: tx1 only, 11: both). `rx_cmp_en` is 1 for any nonzero value. All three follow `drv_en` combinationally.
- R3: After `drv_en` leaves 2'b00, `bus_ready` stays 0 until 11 consecutive recessive samples have been taken. A sample is a cycle with `bit_strobe` = 1, and recessive means `rx_level` = 1. `bus_ready` reads 1 in the cycle after the clock edge that takes the 11th sample.
- R4: While `drv_en` = 2'b00, the integration count is held at zero and `bus_ready` reads 0 from the cycle after the edge. Samples taken while the field is zero are ignored.
- R5: A dominant sample (`rx_level` = 0 with `bit_strobe` = 1) taken before `bus_ready` is set restarts the run, so 11 further recessive samples are needed.
- R6: A change between two nonzero `drv_en` values neither clears `bus_ready` nor discards a partial recessive run.
- R7: Once `bus_ready` is 1, dominant samples do not clear it while `drv_en` is nonzero.
- R8: Cycles with `bit_strobe` = 0 do not advance or reset the run, whatever `rx_level` is.
- R9: While `rst_n` is low, `bus_ready` is 0 and the run count is zero, regardless of `drv_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en | input | 2 | Driver-enable field, bit n enables transmit output n |
| bit_strobe | input | 1 | One-cycle pulse at each bit sample point |
| rx_level | input | 1 | Sampled receive level, 1 = recessive |
| tx0_oe | output | 1 | Output enable for transmit pin 0 |
| tx1_oe | output | 1 | Output enable for transmit pin 1 |
| rx_cmp_en | output | 1 | Receive comparator enable |
| bus_ready | output | 1 | Bus integration finished, frame engine may start |

## Verification
A run counter that is off by one shows up at `bus_ready` exactly one bit sample early or late. The bench therefore tracks the expected rising cycle for every recessive run. A counter that fails to clear on a dominant sample or on disable shows up as a premature `bus_ready` within at most eleven strobes. A ready flag that is cleared by a nonzero-to-nonzero change, or by dominant traffic, drops in the very next cycle. The output-enable decode is visible in the same cycle the field changes.

// File: rtl/can_drv_pkg.sv
package can_drv_pkg;
   localparam int unsigned NUM_TX_PINS = 2;

   typedef enum logic [NUM_TX_PINS-1:0] {
      DRV_OFF  = 2'b00,
      DRV_PIN0 = 2'b01,
      DRV_PIN1 = 2'b10,
      DRV_BOTH = 2'b11
   } drv_mode_e;
endpackage

// File: rtl/can_drv_decode.sv
module can_drv_decode
   import can_drv_pkg::*;
#(
   parameter int unsigned PINS = NUM_TX_PINS
) (
   input  logic [PINS-1:0] en_field,
   output logic [PINS-1:0] pin_oe,
   output logic            cmp_en
);
   if (PINS < 1) begin : g_bad_pins
      $error("can_drv_decode: PINS must be at least 1");
   end

   // one enable bit per transmit pin
   for (genvar p = 0; p < PINS; p++) begin : g_pin
      assign pin_oe[p] = en_field[p];
   end

   // the comparator follows the any-driver-on condition
   always_comb begin
      cmp_en = (en_field != '0);
   end
endmodule

// File: rtl/can_bus_integrator.sv
module can_bus_integrator #(
   parameter int unsigned RUN_LEN      = 11,
   parameter bit          RX_RECESSIVE = 1'b1,
   localparam int unsigned CNT_W       = $clog2(RUN_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             strobe,
   input  logic             rx_level,
   output logic [CNT_W-1:0] run_cnt,
   output logic             ready
);
   if (RUN_LEN < 1) begin : g_bad_len
      $error("can_bus_integrator: RUN_LEN must be at least 1");
   end

   logic is_recessive;

   if (RX_RECESSIVE) begin : g_pol_high
      assign is_recessive = rx_level;
   end else begin : g_pol_low
      assign is_recessive = ~rx_level;
   end

   localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         ready   <= 1'b0;
      end else if (!active) begin
         run_cnt <= '0;
         ready   <= 1'b0;
      end else if (!ready && strobe) begin
         if (!is_recessive) begin
            run_cnt <= '0;
         end else if (run_cnt == LAST) begin
            run_cnt <= '0;
            ready   <= 1'b1;
         end else begin
            run_cnt <= run_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/can_drv_integ.sv
module can_drv_integ
   import can_drv_pkg::*;
#(
   parameter int unsigned RUN_LEN      = 11,
   parameter bit          RX_RECESSIVE = 1'b1,
   localparam int unsigned CNT_W       = $clog2(RUN_LEN + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] drv_en,
   input  logic       bit_strobe,
   input  logic       rx_level,
   output logic       tx0_oe,
   output logic       tx1_oe,
   output logic       rx_cmp_en,
   output logic       bus_ready
);
   logic [NUM_TX_PINS-1:0] pin_oe;
   logic [CNT_W-1:0]       run_cnt;

   can_drv_decode #(.PINS(NUM_TX_PINS)) u_decode (
      .en_field (drv_en),
      .pin_oe   (pin_oe),
      .cmp_en   (rx_cmp_en)
   );

   can_bus_integrator #(
      .RUN_LEN      (RUN_LEN),
      .RX_RECESSIVE (RX_RECESSIVE)
   ) u_integ (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (rx_cmp_en),
      .strobe   (bit_strobe),
      .rx_level (rx_level),
      .run_cnt  (run_cnt),
      .ready    (bus_ready)
   );

   assign tx0_oe = pin_oe[0];
   assign tx1_oe = pin_oe[1];
endmodule

// File: rtl/can_drv_integ_chk.sv
module can_drv_integ_chk #(
   parameter int unsigned RUN_LEN      = 11,
   parameter bit          RX_RECESSIVE = 1'b1,
   localparam int unsigned CNT_W       = $clog2(RUN_LEN + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       drv_en,
   input logic             bit_strobe,
   input logic             rx_level,
   input logic             tx0_oe,
   input logic             tx1_oe,
   input logic             rx_cmp_en,
   input logic             bus_ready,
   input logic [CNT_W-1:0] run_cnt
);
   logic rec;
   assign rec = (rx_level == RX_RECESSIVE);

   p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en == 2'b00) |-> (!tx0_oe && !tx1_oe && !rx_cmp_en));

   p_on_cmp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en != 2'b00) |-> (rx_cmp_en && (tx0_oe || tx1_oe)));

   p_rise_after_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_ready) |-> ($past(bit_strobe) && $past(rec)
                            && ($past(run_cnt) == CNT_W'(RUN_LEN - 1))));

   p_off_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en == 2'b00) |=> (run_cnt == '0 && !bus_ready));

   p_dominant_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en != 2'b00 && bit_strobe && !rec && !bus_ready) |=> (run_cnt == '0 && !bus_ready));

   p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_ready && drv_en != 2'b00) |=> bus_ready);

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_strobe && drv_en != 2'b00) |=> ($stable(run_cnt) && $stable(bus_ready)));

   always_comb begin
      if (!rst_n) begin
         a_reset_state_r9: assert (!bus_ready && run_cnt == '0);
      end
   end
endmodule

bind can_drv_integ can_drv_integ_chk #(
   .RUN_LEN      (RUN_LEN),
   .RX_RECESSIVE (RX_RECESSIVE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .drv_en     (drv_en),
   .bit_strobe (bit_strobe),
   .rx_level   (rx_level),
   .tx0_oe     (tx0_oe),
   .tx1_oe     (tx1_oe),
   .rx_cmp_en  (rx_cmp_en),
   .bus_ready  (bus_ready),
   .run_cnt    (run_cnt)
);

// File: tb/can_drv_integ_tb.sv
`timescale 1ns/100ps
module can_drv_integ_tb;
   localparam int RUN = 11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] drv_en = 2'b11;
   logic       bit_strobe = 1'b0;
   logic       rx_level = 1'b1;
   logic       tx0_oe, tx1_oe, rx_cmp_en, bus_ready;

   always #2.5 clk = ~clk;

   can_drv_integ u_dut (
      .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .bit_strobe(bit_strobe),
      .rx_level(rx_level), .tx0_oe(tx0_oe), .tx1_oe(tx1_oe),
      .rx_cmp_en(rx_cmp_en), .bus_ready(bus_ready)
   );

   typedef struct {
      logic [3:0] exp;   // {tx1_oe, tx0_oe, rx_cmp_en, bus_ready}
      string      tag;
   } item_t;

   item_t q[$];
   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   // requirement-level model state
   bit m_ready = 0;
   int m_cnt   = 0;

   task automatic step(input logic [1:0] d, input logic s, input logic r, input string tag);
      item_t it;
      @(posedge clk);
      #1;
      drv_en = d; bit_strobe = s; rx_level = r;
      it.exp = {d[1], d[0], (d != 2'b00), m_ready};
      it.tag = tag;
      q.push_back(it);
      // state for the coming edge
      if (d == 2'b00) begin
         m_cnt = 0; m_ready = 0;
      end else if (!m_ready && s) begin
         if (!r) m_cnt = 0;
         else if (m_cnt == RUN - 1) begin m_cnt = 0; m_ready = 1; end
         else m_cnt++;
      end
   endtask

   // monitor: compare one item per cycle at the falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         logic [3:0] act;
         it  = q.pop_front();
         act = {tx1_oe, tx0_oe, rx_cmp_en, bus_ready};
         n_vec++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s: actual {tx1,tx0,cmp,rdy}=%b expected %b", it.tag, act, it.exp);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R9: reset state with the field nonzero and strobes active
      bit_strobe = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_vec++;
      if (bus_ready !== 1'b0) begin
         n_bad++;
         $display("FAIL R9: actual bus_ready=%b expected 0", bus_ready);
      end
      @(posedge clk); #1;
      bit_strobe = 1'b0;
      drv_en = 2'b00;
      rst_n = 1'b1;

      // R1, R4: field off, recessive samples ignored
      for (int i = 0; i < 14; i++) step(2'b00, 1'b1, 1'b1, "R1_R4 off");
      // R2, R3: enable pin 0, ten recessive samples then one dominant
      for (int i = 0; i < 10; i++) step(2'b01, 1'b1, 1'b1, "R2_R3 run pin0");
      step(2'b01, 1'b1, 1'b0, "R5 dominant at ten");
      // R8: idle cycles with dominant level, no strobe
      for (int i = 0; i < 4; i++) step(2'b01, 1'b0, 1'b0, "R8 no strobe");
      // R5: full run needed again, interleaved idle cycles
      for (int i = 0; i < RUN; i++) begin
         step(2'b01, 1'b1, 1'b1, "R3_R5 rerun");
         step(2'b01, 1'b0, 1'b0, "R8 gap");
      end
      step(2'b01, 1'b0, 1'b1, "R3 ready after 11th");
      // R6, R7: nonzero changes and dominant traffic keep ready
      step(2'b10, 1'b1, 1'b0, "R6_R2 to pin1");
      step(2'b11, 1'b1, 1'b0, "R6_R7 both");
      for (int i = 0; i < 5; i++) step(2'b11, 1'b1, 1'b0, "R7 dominant traffic");
      // R4: off clears ready
      step(2'b00, 1'b0, 1'b1, "R4 off");
      step(2'b00, 1'b1, 1'b1, "R4 off hold");
      // R6: partial run survives a change of nonzero setting
      for (int i = 0; i < 4; i++) step(2'b10, 1'b1, 1'b1, "R6 partial pin1");
      for (int i = 0; i < 7; i++) step(2'b11, 1'b1, 1'b1, "R6 continue both");
      step(2'b01, 1'b0, 1'b0, "R6 ready kept");
      step(2'b01, 1'b0, 1'b0, "R3 ready stays");
      // R4: re-enable after off must integrate again
      step(2'b00, 1'b0, 1'b1, "R4 off again");
      for (int i = 0; i < RUN; i++) step(2'b10, 1'b1, 1'b1, "R3 reintegrate");
      step(2'b10, 1'b0, 1'b1, "R3 final ready");
      @(posedge clk);
      @(negedge clk);
      @(posedge clk);
      finish_run();
   end
endmodule